// File: doc/BRIEF.md
# SPI Slave Receiver with Chip-Select Supervision

This block is the receive half of an SPI slave. The serial clock, data-in and active-low chip-select pins enter through synchronisers into the system clock domain. While the select is asserted, each detected rising edge of the serial clock shifts one data bit in, most significant bit first. Every completed byte is presented on a data port together with a one-cycle strobe.

Alongside reception, the block supervises the select line. A select that is released while a byte is only partly shifted in is reported as an error pulse. A control input chooses how reception recovers from such an error. With restart recovery, the partial byte is dropped and counting starts again at zero. With resume recovery, the partial bits are kept and the byte is completed once the select returns. In continuous mode, and only when enabled, every select edge also produces an interrupt pulse and sets a sticky status flag for its direction. Software clears these flags with a write-one-to-clear pulse.

Top module: `spi_cs_monitor_rx`

## Requirements
- R1: While cs_ni is low, every rising edge of sclk_i samples mosi_i. After 8 such edges, rx_data_o holds the 8 bits with the first bit in bit 7, and rx_valid_o is high for exactly one clock cycle.
- R2: Rising edges of sclk_i while cs_ni is high shift in no data, produce no rx_valid_o and leave the bit count untouched.
- R3: When cont_mode_i=1 and edge_irq_en_i=1, each cs_ni transition gives a one-cycle edge_irq_o pulse. A high-to-low transition sets cs_fall_o and a low-to-high transition sets cs_rise_o.
- R4: When edge_irq_en_i=0, cs_ni transitions raise no edge_irq_o and set neither status flag.
- R5: When cont_mode_i=0, edge_irq_en_i has no effect: no edge_irq_o pulse and no status flag from any cs_ni transition.
- R6: A low-to-high transition of cs_ni while 1 to 7 bits of the current byte have been received gives a one-cycle err_irq_o pulse. With 0 bits received it gives none.
- R7: With err_rst_en_i=1 at the error, the received bits are discarded. The next byte starts from bit count zero.
- R8: With err_rst_en_i=0 at the error, the bit count and the received bits are kept. The remaining bits complete the same byte after cs_ni goes low again.
- R9: cs_rise_o and cs_fall_o stay set until cleared. A cycle with flag_clr_i[0]=1 clears cs_rise_o, and a cycle with flag_clr_i[1]=1 clears cs_fall_o. Each clear bit leaves the other flag unchanged.
- R10: After reset, rx_data_o, rx_valid_o, cs_rise_o, cs_fall_o, edge_irq_o and err_irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| mosi_i | input | 1 | Serial data-in pin (asynchronous) |
| cs_ni | input | 1 | Chip select pin, active low (asynchronous) |
| cont_mode_i | input | 1 | Continuous transfer mode |
| edge_irq_en_i | input | 1 | Enable select-edge interrupts and flags (continuous mode only) |
| err_rst_en_i | input | 1 | 1: restart bit count after select error, 0: resume |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 rise flag, bit 1 fall flag |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte |
| cs_rise_o | output | 1 | Sticky flag: select released |
| cs_fall_o | output | 1 | Sticky flag: select asserted |
| edge_irq_o | output | 1 | One-cycle pulse per select edge |
| err_irq_o | output | 1 | One-cycle pulse on mid-byte select release |

## Verification
The hardest state to reach from the ports is a byte split across two select windows, where the bits received before the break must either survive or vanish depending on the recovery mode. The stimulus table builds this state by clocking a chosen number of bits from a 16-bit stream, releasing the select, and then resuming the same stream in a second window. The received byte value therefore shows which bits were kept. One entry splits two bytes at bit 5, so that a resumed byte and the byte after it both have to come out correct.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_SYNC_STAGES = 2;
  // pin vector layout into the synchroniser
  localparam int PIN_SCLK = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_CS   = 2;
  localparam int PIN_W    = 3;
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/spi_mon_shift.sv
module spi_mon_shift #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              mosi_i,
  input  logic              cs_active_i,
  input  logic              cs_release_i,
  input  logic              err_rst_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, sh_nxt;

  assign sh_nxt = {sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (cs_release_i && cnt_q != '0) begin
        err_o <= 1'b1;
        if (err_rst_en_i) begin
          cnt_q <= '0;
          sh_q  <= '0;
        end
      end else if (sclk_rise_i && cs_active_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          data_o  <= sh_nxt;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_mon_csflags.sv
module spi_mon_csflags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_assert_i,
  input  logic       cs_release_i,
  input  logic       cont_mode_i,
  input  logic       edge_irq_en_i,
  input  logic [1:0] clr_i,
  output logic       rise_o,
  output logic       fall_o,
  output logic       irq_o
);
  logic gate;
  assign gate = cont_mode_i & edge_irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      // new event wins over a clear in the same cycle
      rise_o <= (rise_o & ~clr_i[0]) | (gate & cs_release_i);
      fall_o <= (fall_o & ~clr_i[1]) | (gate & cs_assert_i);
      irq_o  <= gate & (cs_release_i | cs_assert_i);
    end
  end
endmodule

// File: rtl/spi_cs_monitor_rx.sv
module spi_cs_monitor_rx
  import spi_mon_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  input  logic              cont_mode_i,
  input  logic              edge_irq_en_i,
  input  logic              err_rst_en_i,
  input  logic [1:0]        flag_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              cs_rise_o,
  output logic              cs_fall_o,
  output logic              edge_irq_o,
  output logic              err_irq_o
);
  logic [PIN_W-1:0] pin_raw, pin_s;
  logic [1:0]       edg_in, edg_rise, edg_fall;
  logic             sclk_rise, cs_assert, cs_release, cs_active;
  logic [CNT_W-1:0] bit_cnt;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_SCLK] = sclk_i;
    pin_raw[PIN_MOSI] = mosi_i;
    pin_raw[PIN_CS]   = cs_ni;
  end

  spi_mon_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_W'(1) << PIN_CS)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_raw), .q_o(pin_s)
  );

  assign edg_in = {pin_s[PIN_CS], pin_s[PIN_SCLK]};

  spi_mon_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(edg_in),
    .rise_o(edg_rise), .fall_o(edg_fall)
  );

  assign sclk_rise  = edg_rise[0];
  assign cs_release = edg_rise[1];
  assign cs_assert  = edg_fall[1];
  assign cs_active  = ~pin_s[PIN_CS];

  spi_mon_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_rise_i(sclk_rise), .mosi_i(pin_s[PIN_MOSI]),
    .cs_active_i(cs_active), .cs_release_i(cs_release),
    .err_rst_en_i(err_rst_en_i),
    .data_o(rx_data_o), .valid_o(rx_valid_o), .err_o(err_irq_o),
    .cnt_o(bit_cnt)
  );

  spi_mon_csflags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_assert_i(cs_assert), .cs_release_i(cs_release),
    .cont_mode_i(cont_mode_i), .edge_irq_en_i(edge_irq_en_i),
    .clr_i(flag_clr_i),
    .rise_o(cs_rise_o), .fall_o(cs_fall_o), .irq_o(edge_irq_o)
  );
endmodule

// File: rtl/spi_mon_chk.sv
module spi_mon_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cont_mode_i,
  input logic             edge_irq_en_i,
  input logic             err_rst_en_i,
  input logic [1:0]       flag_clr_i,
  input logic             rx_valid_o,
  input logic             cs_rise_o,
  input logic             cs_fall_o,
  input logic             edge_irq_o,
  input logic             err_irq_o,
  input logic [CNT_W-1:0] bit_cnt
);
  p_valid_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_edge_irq_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_irq_o |-> $past(edge_irq_en_i));

  p_edge_irq_cont_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_irq_o |-> $past(cont_mode_i));

  p_err_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |=> !err_irq_o);

  p_err_partial_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> $past(bit_cnt) != '0);

  p_cnt_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o && $past(err_rst_en_i)) |-> bit_cnt == '0);

  p_cnt_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o && !$past(err_rst_en_i)) |-> bit_cnt == $past(bit_cnt));

  p_rise_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_rise_o && !flag_clr_i[0]) |-> cs_rise_o);

  p_fall_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_fall_o && !flag_clr_i[1]) |-> cs_fall_o);
endmodule

bind spi_cs_monitor_rx spi_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cont_mode_i(cont_mode_i),
  .edge_irq_en_i(edge_irq_en_i), .err_rst_en_i(err_rst_en_i),
  .flag_clr_i(flag_clr_i), .rx_valid_o(rx_valid_o), .cs_rise_o(cs_rise_o),
  .cs_fall_o(cs_fall_o), .edge_irq_o(edge_irq_o), .err_irq_o(err_irq_o),
  .bit_cnt(bit_cnt)
);

// File: tb/spi_cs_monitor_rx_tb.sv
module spi_cs_monitor_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic cont = 1'b0, ien = 1'b0, ers = 1'b0;
  logic [1:0] fclr = 2'b00;
  logic [7:0] rx_data;
  logic rx_valid, f_rise, f_fall, eirq, xirq;

  int checks = 0, errors = 0;
  int n_bytes = 0, n_edge = 0, n_err = 0;
  logic [7:0] last_byte = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_cs_monitor_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_ni(cs_n),
    .cont_mode_i(cont), .edge_irq_en_i(ien), .err_rst_en_i(ers),
    .flag_clr_i(fclr), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .cs_rise_o(f_rise), .cs_fall_o(f_fall), .edge_irq_o(eirq), .err_irq_o(xirq)
  );

  // pulse counters, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin n_bytes++; last_byte = rx_data; end
      if (eirq) n_edge++;
      if (xirq) n_err++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); mosi = b; sclk = 1'b0;
    idle(4);
    sclk = 1'b1;
    idle(4);
    sclk = 1'b0;
  endtask

  task automatic cs_low;  @(negedge clk); cs_n = 1'b0; idle(6); endtask
  task automatic cs_high; @(negedge clk); cs_n = 1'b1; idle(8); endtask

  task automatic clear_flags(input logic [1:0] v);
    @(negedge clk); fclr = v;
    @(negedge clk); fclr = 2'b00;
    idle(1);
  endtask

  typedef struct packed {
    logic        cont;
    logic        ien;
    logic        ers;
    logic [4:0]  n1;
    logic [4:0]  n2;
    logic [15:0] stream;
    logic [1:0]  nbytes;
    logic [7:0]  last;
    logic [2:0]  nedge;
    logic        nerr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b0,5'd8,5'd0,16'hA500,2'd1,8'hA5,3'd0,1'b0}, // R1 plain byte
    '{1'b1,1'b1,1'b0,5'd8,5'd0,16'h3C00,2'd1,8'h3C,3'd2,1'b0}, // R3 edges
    '{1'b0,1'b1,1'b0,5'd8,5'd0,16'h0F00,2'd1,8'h0F,3'd0,1'b0}, // R5 not cont
    '{1'b1,1'b0,1'b0,5'd8,5'd0,16'hF000,2'd1,8'hF0,3'd0,1'b0}, // R4 disabled
    '{1'b0,1'b0,1'b0,5'd3,5'd5,16'hC300,2'd1,8'hC3,3'd0,1'b1}, // R8 resume
    '{1'b0,1'b0,1'b1,5'd3,5'd8,16'hAB40,2'd1,8'h5A,3'd0,1'b1}, // R7 restart
    '{1'b1,1'b1,1'b1,5'd4,5'd8,16'hF810,2'd1,8'h81,3'd4,1'b1}, // R7 R3
    '{1'b1,1'b1,1'b0,5'd5,5'd11,16'h1234,2'd2,8'h34,3'd4,1'b1},// R8 two bytes
    '{1'b1,1'b1,1'b0,5'd0,5'd0,16'h0000,2'd0,8'h00,3'd2,1'b0}  // R6 no bits
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R10 reset state
    chk("R10 rx_data", rx_data, 0);
    chk("R10 rx_valid", rx_valid, 0);
    chk("R10 flags", {f_rise, f_fall}, 0);
    chk("R10 irqs", {eirq, xirq}, 0);
    rst_n = 1'b1;
    idle(4);
    chk("R10 after release", {rx_valid, f_rise, f_fall, eirq, xirq}, 0);

    for (int v = 0; v < NV; v++) begin
      int b0, e0, x0, idx;
      @(negedge clk);
      cont = VT[v].cont; ien = VT[v].ien; ers = VT[v].ers;
      b0 = n_bytes; e0 = n_edge; x0 = n_err; idx = 15;
      cs_low;
      for (int i = 0; i < VT[v].n1; i++) begin send_bit(VT[v].stream[idx]); idx--; end
      cs_high;
      if (VT[v].n2 != 0) begin
        cs_low;
        for (int i = 0; i < VT[v].n2; i++) begin send_bit(VT[v].stream[idx]); idx--; end
        cs_high;
      end
      chk($sformatf("R1 bytes v%0d", v), n_bytes - b0, VT[v].nbytes);
      if (VT[v].nbytes != 0) chk($sformatf("R1 R7 R8 data v%0d", v), last_byte, VT[v].last);
      chk($sformatf("R3 R4 R5 edge irqs v%0d", v), n_edge - e0, VT[v].nedge);
      chk($sformatf("R6 errors v%0d", v), n_err - x0, VT[v].nerr);
      chk($sformatf("R3 R4 R5 flags v%0d", v), {f_rise, f_fall},
          (VT[v].nedge != 0) ? 2'b11 : 2'b00);
      idle(20);
      chk($sformatf("R9 sticky v%0d", v), {f_rise, f_fall},
          (VT[v].nedge != 0) ? 2'b11 : 2'b00);
      clear_flags(2'b01);
      chk($sformatf("R9 clear rise v%0d", v), {f_rise, f_fall},
          (VT[v].nedge != 0) ? 2'b01 : 2'b00);
      clear_flags(2'b10);
      chk($sformatf("R9 clear fall v%0d", v), {f_rise, f_fall}, 2'b00);
    end

    // R2: serial clocks with select released are ignored
    begin
      int b0, x0;
      @(negedge clk); cont = 1'b0; ien = 1'b0; ers = 1'b0;
      b0 = n_bytes; x0 = n_err;
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      idle(6);
      chk("R2 no byte with cs high", n_bytes - b0, 0);
      cs_low;
      for (int i = 0; i < 8; i++) send_bit(8'h96 >> (7 - i));
      cs_high;
      chk("R2 next byte count", n_bytes - b0, 1);
      chk("R2 next byte aligned", last_byte, 8'h96);
      chk("R2 R6 no error", n_err - x0, 0);
    end

    // R9: clear of fall flag only keeps rise flag
    begin
      @(negedge clk); cont = 1'b1; ien = 1'b1;
      cs_low; cs_high;
      clear_flags(2'b10);
      chk("R9 fall cleared only", {f_rise, f_fall}, 2'b10);
      clear_flags(2'b01);
      chk("R9 rise cleared", {f_rise, f_fall}, 2'b00);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule